// File: doc/BRIEF.md
# Four-Phase Handshake Word Crossing

This block moves a multi-bit word from a source clock domain into an unrelated destination clock domain. The data lines are never resynchronized. Only two single-bit flags cross the boundary: a ready flag going from source to destination and an acknowledge flag coming back. Each flag passes through a chain of flip-flops in the domain that receives it, and the chain depth is a parameter. The source holds its word steady for the whole time ready is raised. The destination therefore captures the word only when it is already settled.

The word source is an internal counter, and it advances only once its current value has been acknowledged. Every word seen at the destination is therefore exactly one higher than the word before it, wrapping at the width of the bus. A source-side enable decides whether a new word is offered. The destination reports each captured word with a one-cycle valid strobe. Each domain has its own synchronous active-low reset.

Top module: `handshake_xfer`

## Requirements
- R1: While the resets are held low, `src_ready`, `dst_ack` and `dst_valid` are 0, and `src_data` and `dst_data` are all zeros.
- R2: The first word delivered after reset is 0, which is the counter's reset value.
- R3: Every later delivered word equals the previous delivered word plus one, modulo 2^DATA_W. The sequence wraps from all ones to zero.
- R4: `dst_valid` is high for exactly one destination clock cycle per word, and never for two consecutive cycles.
- R5: While `src_ready` stays high, `src_data` does not change.
- R6: The flags follow a four-phase order. `src_ready` rises only while `dst_ack` is low. `dst_ack` rises only while `src_ready` is high. `src_ready` falls only while `dst_ack` is high. `dst_ack` falls only while `src_ready` is low.
- R7: `dst_valid` and the rise of `dst_ack` come SYNC_STAGES+1 destination rising edges after `src_ready` rises. `src_ready` falls SYNC_STAGES+1 source rising edges after `dst_ack` rises.
- R8: While `src_enable` is low and no handshake is in flight, `src_ready` stays low, `src_data` keeps its value and no word is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| src_enable | input | 1 | Allows the source to offer its next word |
| src_ready | output | 1 | Ready flag: the word on `src_data` is on offer |
| src_data | output | DATA_W | Source word bus, held while ready is high |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| dst_ack | output | 1 | Acknowledge flag returned to the source |
| dst_valid | output | 1 | One-cycle strobe marking a newly captured word |
| dst_data | output | DATA_W | Captured word |

## Verification
A new word shows up on `dst_valid` at the (SYNC_STAGES+1)th destination rising edge after `src_ready` rises. The source lowers ready at the (SYNC_STAGES+1)th source rising edge after `dst_ack` rises. The bench counts the clock edges of each domain from each flag transition and compares the counts to these figures.

The two clocks have unrelated periods, and their edges never coincide. This lets every flag transition be placed unambiguously between edges of the other clock. Outputs are sampled on the falling edge of the clock that owns them. The bench checks each delivered word against a running expected value, held while the enable is low.

// File: rtl/xfer_pkg.sv
// Shared state encodings for the handshake word crossing.
// Assumes: nothing beyond a SystemVerilog 2017 compiler.
package xfer_pkg;

    // Source-side handshake phases
    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,   // no word on offer
        SRC_OFFER  = 2'd1,   // ready high, waiting for acknowledge
        SRC_RETIRE = 2'd2    // ready low, waiting for acknowledge to drop
    } src_state_t;

    // Destination-side handshake phases
    typedef enum logic {
        DST_IDLE = 1'b0,     // waiting for ready
        DST_HOLD = 1'b1      // acknowledge high, waiting for ready to drop
    } dst_state_t;

endpackage

// File: rtl/flag_sync.sv
// Multi-flop synchronizer for one control flag entering a clock domain.
// Assumes: STAGES >= 2; the input is a single level-type flag from
// another domain; the chain flops must stay separate registers placed
// close together so that a metastable first stage has time to settle.
module flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_in,
    output logic flag_out
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Shift the asynchronous flag through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], flag_in};
    end

    assign flag_out = chain_q[TOP];

endmodule

// File: rtl/xfer_src.sv
// Source side of the crossing: a word counter, the ready flag and the
// synchronizer for the returning acknowledge.
// Assumes: the destination samples word_o only after its synchronized
// copy of ready is high; the word is frozen until acknowledge is seen.
module xfer_src
    import xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ack_async,
    output logic              ready_o,
    output logic [DATA_W-1:0] word_o
);

    src_state_t        state_q;
    logic              ready_q;
    logic [DATA_W-1:0] word_q;
    logic              ack_s;

    flag_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_in (ack_async),
        .flag_out(ack_s)
    );

    // Four-phase source sequencing; the counter steps as ready drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
            ready_q <= 1'b0;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                SRC_IDLE: begin
                    if (enable && !ack_s) begin
                        ready_q <= 1'b1;
                        state_q <= SRC_OFFER;
                    end
                end
                SRC_OFFER: begin
                    if (ack_s) begin
                        ready_q <= 1'b0;
                        word_q  <= word_q + 1'b1;
                        state_q <= SRC_RETIRE;
                    end
                end
                SRC_RETIRE: begin
                    if (!ack_s) state_q <= SRC_IDLE;
                end
                default: state_q <= SRC_IDLE;
            endcase
        end
    end

    assign ready_o = ready_q;
    assign word_o  = word_q;

    // R5: the offered word holds while ready stays high
    a_r5_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> (!ready_q || $stable(word_q)));

    // R6: ready rises only while the synchronized acknowledge is low
    a_r6_ready_rise_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> !$past(ack_s));

    // R6: ready falls only after acknowledge has been seen
    a_r6_ready_fall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_q) |-> $past(ack_s));

    // R3: each retired word is followed by its successor
    a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_q) |-> (word_q == DATA_W'($past(word_q) + 1'b1)));

endmodule

// File: rtl/xfer_dst.sv
// Destination side of the crossing: synchronizes ready, captures the
// word, pulses valid once and drives acknowledge.
// Assumes: the word bus is stable whenever the synchronized ready is high.
module xfer_dst
    import xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_async,
    input  logic [DATA_W-1:0] word_async,
    output logic              ack_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    dst_state_t        state_q;
    logic              ack_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              rdy_s;

    flag_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_in (ready_async),
        .flag_out(rdy_s)
    );

    // Capture on synchronized ready, hold acknowledge until ready drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DST_IDLE;
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                DST_IDLE: begin
                    if (rdy_s) begin
                        data_q  <= word_async;
                        valid_q <= 1'b1;
                        ack_q   <= 1'b1;
                        state_q <= DST_HOLD;
                    end
                end
                DST_HOLD: begin
                    if (!rdy_s) begin
                        ack_q   <= 1'b0;
                        state_q <= DST_IDLE;
                    end
                end
                default: state_q <= DST_IDLE;
            endcase
        end
    end

    assign ack_o   = ack_q;
    assign valid_o = valid_q;
    assign data_o  = data_q;

    // R4: the valid strobe never lasts two cycles
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R4: each strobe coincides with the rise of acknowledge
    a_r4_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $rose(ack_q));

    // R6: acknowledge rises only after synchronized ready was high
    a_r6_ack_rise_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(rdy_s));

    // R6: acknowledge falls only after synchronized ready was low
    a_r6_ack_fall_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(rdy_s));

endmodule

// File: rtl/handshake_xfer.sv
// Top of the handshake word crossing: ties the source and destination
// halves together. Only ready and acknowledge cross through synchronizers;
// the word bus feeds the destination capture register directly.
// Assumes: two independent clocks, each with its own synchronous reset.
module handshake_xfer #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_enable,
    output logic              src_ready,
    output logic [DATA_W-1:0] src_data,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_ack,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);

    xfer_src #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .enable   (src_enable),
        .ack_async(dst_ack),
        .ready_o  (src_ready),
        .word_o   (src_data)
    );

    xfer_dst #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
        .clk        (dst_clk),
        .rst_n      (dst_rst_n),
        .ready_async(src_ready),
        .word_async (src_data),
        .ack_o      (dst_ack),
        .valid_o    (dst_valid),
        .data_o     (dst_data)
    );

endmodule

// File: tb/handshake_xfer_test.sv
`timescale 1ns/10ps
module handshake_xfer_test;

    localparam int W    = 8;
    localparam int SYNC = 2;

    logic         src_clk = 1'b0, dst_clk = 1'b0;
    logic         src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic         src_enable = 1'b0;
    logic         src_ready, dst_ack, dst_valid;
    logic [W-1:0] src_data, dst_data;

    int checks = 0, failures = 0;
    bit mon_on = 0, finished = 0;

    handshake_xfer #(.DATA_W(W), .SYNC_STAGES(SYNC)) uut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_enable(src_enable),
        .src_ready(src_ready), .src_data(src_data),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_ack(dst_ack),
        .dst_valid(dst_valid), .dst_data(dst_data)
    );

    // 50 MHz source clock; unrelated destination clock whose edges never meet it
    always #10 src_clk = ~src_clk;
    initial begin
        #0.33;
        forever #6.7 dst_clk = ~dst_clk;
    end

    function automatic logic [W-1:0] next_word(input logic [W-1:0] w);
        return W'(w + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Delivered-word monitor: R2, R3, R4, R7
    logic [W-1:0] exp_word = '0;
    int  words = 0;
    bit  prev_valid = 0;
    int  dcount = 0, scount = 0;
    bit  dmeas = 0, smeas = 0;

    always @(posedge src_ready) begin dcount = 0; dmeas = 1; end
    always @(posedge dst_clk) if (dmeas) dcount++;
    always @(posedge dst_ack) begin scount = 0; smeas = 1; end
    always @(posedge src_clk) if (smeas) scount++;

    always @(negedge dst_clk) begin
        if (mon_on) begin
            if (dst_valid) begin
                check(dst_data == exp_word, words == 0 ? "R2" : "R3", dst_data, exp_word);
                check(!prev_valid, "R4", prev_valid, 0);
                if (dmeas) check(dcount == SYNC + 1, "R7 valid latency", dcount, SYNC + 1);
                dmeas = 0;
                exp_word = next_word(exp_word);
                words++;
            end
            prev_valid = dst_valid;
        end
    end

    // R7: ready release latency counted in source edges
    always @(negedge src_ready) begin
        if (mon_on && smeas) check(scount == SYNC + 1, "R7 release latency", scount, SYNC + 1);
        smeas = 0;
    end

    // R6: four-phase ordering of the two flags
    always @(posedge src_ready) if (mon_on) check(dst_ack == 1'b0, "R6 ready rise", dst_ack, 0);
    always @(posedge dst_ack)   if (mon_on) check(src_ready == 1'b1, "R6 ack rise", src_ready, 1);
    always @(negedge src_ready) if (mon_on) check(dst_ack == 1'b1, "R6 ready fall", dst_ack, 1);
    always @(negedge dst_ack)   if (mon_on) check(src_ready == 1'b0, "R6 ack fall", src_ready, 0);

    // R5: word stays put while ready is high
    bit           prev_ready = 0;
    logic [W-1:0] prev_data = '0;
    always @(negedge src_clk) begin
        if (mon_on && src_ready && prev_ready)
            check(src_data == prev_data, "R5", src_data, prev_data);
        prev_ready = src_ready;
        prev_data  = src_data;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge src_clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [W-1:0] held;
        int           seen;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (6) @(negedge src_clk);
        check(src_ready == 1'b0, "R1 ready", src_ready, 0);
        check(dst_ack == 1'b0, "R1 ack", dst_ack, 0);
        check(dst_valid == 1'b0, "R1 valid", dst_valid, 0);
        check(src_data == '0, "R1 src_data", src_data, 0);
        check(dst_data == '0, "R1 dst_data", dst_data, 0);
        mon_on = 1;
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;

        // Random enable pattern
        for (int i = 0; i < 2500; i++) begin
            @(negedge src_clk);
            src_enable = ($urandom % 4) != 0;
        end

        // R8: enable low after the in-flight handshake drains
        @(negedge src_clk);
        src_enable = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge src_clk);
            if (!src_ready && !dst_ack) break;
        end
        repeat (4) @(negedge src_clk);
        held = src_data;
        seen = words;
        for (int i = 0; i < 40; i++) begin
            @(negedge src_clk);
            if (src_ready) check(0, "R8 ready stayed low", src_ready, 0);
        end
        check(src_data == held, "R8 word held", src_data, held);
        check(words == seen, "R8 no delivery", words, seen);

        // Back-to-back offers
        @(negedge src_clk);
        src_enable = 1'b1;
        repeat (800) @(negedge src_clk);
        src_enable = 1'b0;
        repeat (60) @(negedge src_clk);

        // R3: enough words delivered to pass the wrap point
        check(words > (1 << W), "R3 wrap reached", words, (1 << W) + 1);
        summary();
    end

endmodule